// File: doc/BRIEF.md
# Video and Control Output Demultiplexer

This block is the parallel output stage of a link receiver. Each recovered word arrives with a strobe and a one-bit tag. The tag says whether the word carries pixel data or control data. Pixel words go out on an 18-bit video bus and control words go out on a 9-bit control bus. A data-enable output follows the tag of the most recent word. A bus that is not being written keeps its last value, so a downstream device sees stable data during blanking and during pixel runs.

The video bus does not change all at once. It is split into three six-bit groups, and each group updates one clock after the one before it. This spreads the switching current over three cycles. The output clock is the stage clock, either passed through or inverted, chosen so that the receiving device can capture on either edge. A blank request forces every data output low while the upstream timing settles. A drive-enable output tells the pad ring when to release all buses and the output clock to high impedance. The lock indication bypasses all gating.

Top module: `vcd_out_stage`

## Requirements
- R1: A strobed word with the tag at 1 sets `de_o` to 1 and places word bits 5:0 on `video_o[5:0]` at the first rising clock edge after the strobe edge.
- R2: A strobed word with the tag at 0 places word bits 8:0 on `ctl_o` and clears `de_o` at the first rising edge after the strobe edge. The video bus is left unchanged.
- R3: Without the strobe, `ctl_o` and `de_o` hold their values. A video word leaves `ctl_o` unchanged.
- R4: For a video word, `video_o[11:6]` takes word bits 11:6 one cycle after bits 5:0 update, and `video_o[17:12]` takes word bits 17:12 one cycle after that. Words may arrive on back-to-back cycles.
- R5: `pad_drive_o` equals `oe_i`; 0 means the pad ring holds the buses and `pclk_o` in high impedance. While `oe_i` is low, the internal data keeps updating and `lock_o` is unaffected.
- R6: With `rise_sel_i` at 1, `pclk_o` is the inverse of `clk_i`, so capture happens on its rising edge mid-cycle. With `rise_sel_i` at 0, `pclk_o` equals `clk_i`, so capture happens on its falling edge mid-cycle.
- R7: While `blank_i` is 1, `video_o`, `ctl_o` and `de_o` read 0. Words strobed during blanking are still stored, and they appear once blanking ends.
- R8: While reset is asserted, `video_o`, `ctl_o` and `de_o` are 0.
- R9: `lock_o` always equals `lock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stage clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 27 | Recovered word |
| de_tag_i | input | 1 | 1 = video word, 0 = control word |
| word_vld_i | input | 1 | Word strobe |
| oe_i | input | 1 | Output enable |
| rise_sel_i | input | 1 | 1 = capture on rising edge of pclk_o |
| blank_i | input | 1 | Force data outputs low |
| lock_i | input | 1 | Lock indication from the receiver |
| video_o | output | 18 | Staggered video bus |
| ctl_o | output | 9 | Control bus |
| de_o | output | 1 | Data-enable output |
| pclk_o | output | 1 | Output clock |
| pad_drive_o | output | 1 | Pad driver enable |
| lock_o | output | 1 | Lock pass-through |

## Verification
Suppose the stagger delay line held a wrong valid bit or wrong data. The upper video groups would then show the wrong slice, or update at the wrong time, two or three cycles after the strobe. Suppose instead the routing or hold registers were wrong. The error would appear on the very next cycle: either the idle bus would change, or `de_o` would not follow the tag. The scoreboard compares every output on every cycle. This includes back-to-back video words, where two groups hold pieces of different words at the same time.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam int unsigned VCD_WORD_W = 27;
  localparam int unsigned VCD_VID_W  = 18;
  localparam int unsigned VCD_CTL_W  = 9;
  localparam int unsigned VCD_GRP_W  = 6;
endpackage

// File: rtl/vcd_rst_sync.sv
module vcd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/vcd_vid_stagger.sv
module vcd_vid_stagger #(
  parameter int unsigned VID_W = 18,
  parameter int unsigned GRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VID_W-1:0] data_i,
  output logic [VID_W-1:0] video_o
);
  localparam int unsigned NGRP = VID_W / GRP_W;

  // tap k carries the word that group k loads this cycle
  logic [NGRP-1:0]  tap_vld;
  logic [VID_W-1:0] tap_dat [NGRP];
  logic [NGRP-1:1]  dly_vld_q, dly_vld_d;
  logic [VID_W-1:0] dly_dat_q [NGRP-1:1];
  logic [VID_W-1:0] dly_dat_d [NGRP-1:1];
  logic [GRP_W-1:0] grp_q [NGRP];
  logic [GRP_W-1:0] grp_d [NGRP];

  assign tap_vld[0] = load_i;
  assign tap_dat[0] = data_i;

  genvar k;
  generate
    for (k = 1; k < NGRP; k++) begin : g_tap
      assign tap_vld[k]   = dly_vld_q[k];
      assign tap_dat[k]   = dly_dat_q[k];
      assign dly_vld_d[k] = tap_vld[k-1];
      assign dly_dat_d[k] = tap_vld[k-1] ? tap_dat[k-1] : dly_dat_q[k];
    end
    for (k = 0; k < NGRP; k++) begin : g_grp
      assign grp_d[k] = tap_vld[k] ? tap_dat[k][k*GRP_W +: GRP_W] : grp_q[k];
      assign video_o[k*GRP_W +: GRP_W] = grp_q[k];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_vld_q <= '0;
      for (int i = 1; i < NGRP; i++) dly_dat_q[i] <= '0;
      for (int i = 0; i < NGRP; i++) grp_q[i] <= '0;
    end else begin
      dly_vld_q <= dly_vld_d;
      for (int i = 1; i < NGRP; i++) dly_dat_q[i] <= dly_dat_d[i];
      for (int i = 0; i < NGRP; i++) grp_q[i] <= grp_d[i];
    end
  end
endmodule

// File: rtl/vcd_ctl_path.sv
module vcd_ctl_path #(
  parameter int unsigned CTL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             tag_i,
  input  logic [CTL_W-1:0] data_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             de_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             de_q, de_d;
  logic             ctl_en;

  always_comb begin
    ctl_en = vld_i && !tag_i;
    ctl_d  = ctl_en ? data_i : ctl_q;
    de_d   = vld_i ? tag_i : de_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      de_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      de_q  <= de_d;
    end
  end

  assign ctl_o = ctl_q;
  assign de_o  = de_q;
endmodule

// File: rtl/vcd_pad_stage.sv
module vcd_pad_stage #(
  parameter int unsigned VID_W = 18,
  parameter int unsigned CTL_W = 9
) (
  input  logic             clk_i,
  input  logic             blank_i,
  input  logic             oe_i,
  input  logic             rise_sel_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             de_i,
  output logic [VID_W-1:0] video_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             de_o,
  output logic             pclk_o,
  output logic             pad_drive_o
);
  always_comb begin
    video_o     = blank_i ? '0 : vid_i;
    ctl_o       = blank_i ? '0 : ctl_i;
    de_o        = blank_i ? 1'b0 : de_i;
    // inverted clock puts its rising edge mid-cycle
    pclk_o      = clk_i ^ rise_sel_i;
    pad_drive_o = oe_i;
  end
endmodule

// File: rtl/vcd_out_stage.sv
module vcd_out_stage
  import vcd_pkg::*;
#(
  parameter int unsigned WORD_W = VCD_WORD_W,
  parameter int unsigned VID_W  = VCD_VID_W,
  parameter int unsigned CTL_W  = VCD_CTL_W,
  parameter int unsigned GRP_W  = VCD_GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              de_tag_i,
  input  logic              word_vld_i,
  input  logic              oe_i,
  input  logic              rise_sel_i,
  input  logic              blank_i,
  input  logic              lock_i,
  output logic [VID_W-1:0]  video_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              de_o,
  output logic              pclk_o,
  output logic              pad_drive_o,
  output logic              lock_o
);
  logic             rst_int_n;
  logic             vid_load;
  logic [VID_W-1:0] vid_q;
  logic [CTL_W-1:0] ctl_q;
  logic             de_q;

  assign vid_load = word_vld_i && de_tag_i;

  vcd_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  vcd_vid_stagger #(.VID_W(VID_W), .GRP_W(GRP_W)) u_vid (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .load_i  (vid_load),
    .data_i  (word_i[VID_W-1:0]),
    .video_o (vid_q)
  );

  vcd_ctl_path #(.CTL_W(CTL_W)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .vld_i  (word_vld_i),
    .tag_i  (de_tag_i),
    .data_i (word_i[CTL_W-1:0]),
    .ctl_o  (ctl_q),
    .de_o   (de_q)
  );

  vcd_pad_stage #(.VID_W(VID_W), .CTL_W(CTL_W)) u_pad (
    .clk_i       (clk_i),
    .blank_i     (blank_i),
    .oe_i        (oe_i),
    .rise_sel_i  (rise_sel_i),
    .vid_i       (vid_q),
    .ctl_i       (ctl_q),
    .de_i        (de_q),
    .video_o     (video_o),
    .ctl_o       (ctl_o),
    .de_o        (de_o),
    .pclk_o      (pclk_o),
    .pad_drive_o (pad_drive_o)
  );

  assign lock_o = lock_i;
endmodule

// File: rtl/vcd_out_checker.sv
module vcd_out_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [26:0] word_i,
  input logic        de_tag_i,
  input logic        word_vld_i,
  input logic        oe_i,
  input logic        blank_i,
  input logic        lock_i,
  input logic [17:0] video_o,
  input logic [8:0]  ctl_o,
  input logic        de_o,
  input logic        pad_drive_o,
  input logic        lock_o
);
  assert_video_de_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && de_tag_i) |=> (blank_i || (de_o && video_o[5:0] == $past(word_i[5:0]))));

  assert_ctl_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && !de_tag_i) |=> (blank_i || (!de_o && ctl_o == $past(word_i[8:0]))));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_vld_i) |=> (blank_i || $past(blank_i) || ($stable(ctl_o) && $stable(de_o))));

  assert_stagger_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && de_tag_i) |=> ##1 (blank_i || video_o[11:6] == $past(word_i[11:6], 2)));

  assert_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_drive_o == oe_i);

  assert_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> (video_o == '0 && ctl_o == '0 && !de_o));

  assert_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o == lock_i);
endmodule

bind vcd_out_stage vcd_out_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_i      (word_i),
  .de_tag_i    (de_tag_i),
  .word_vld_i  (word_vld_i),
  .oe_i        (oe_i),
  .blank_i     (blank_i),
  .lock_i      (lock_i),
  .video_o     (video_o),
  .ctl_o       (ctl_o),
  .de_o        (de_o),
  .pad_drive_o (pad_drive_o),
  .lock_o      (lock_o)
);

// File: tb/vcd_out_stage_bench.sv
module vcd_out_stage_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [26:0] word_i = '0;
  logic        de_tag_i = 1'b0;
  logic        word_vld_i = 1'b0;
  logic        oe_i = 1'b1;
  logic        rise_sel_i = 1'b1;
  logic        blank_i = 1'b0;
  logic        lock_i = 1'b0;
  logic [17:0] video_o;
  logic [8:0]  ctl_o;
  logic        de_o;
  logic        pclk_o;
  logic        pad_drive_o;
  logic        lock_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  vcd_out_stage u_vcd_out_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i), .de_tag_i(de_tag_i),
    .word_vld_i(word_vld_i), .oe_i(oe_i), .rise_sel_i(rise_sel_i),
    .blank_i(blank_i), .lock_i(lock_i), .video_o(video_o), .ctl_o(ctl_o),
    .de_o(de_o), .pclk_o(pclk_o), .pad_drive_o(pad_drive_o), .lock_o(lock_o)
  );

  typedef struct {
    logic [17:0] vid;
    logic [8:0]  ctl;
    logic        de;
    logic        pclk;
    logic        drv;
    logic        lock;
    string       req;
  } exp_t;

  exp_t  sb_q[$];
  event  chk_ev;
  string cur_req = "R8";

  // reference state built from the requirements
  logic [5:0]  m_g0, m_g1, m_g2;
  logic [8:0]  m_ctl;
  logic        m_de;
  logic [17:0] m_p1, m_p2;
  logic        m_p1v, m_p2v;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    exp_t e;
    @(posedge clk_i);
    if (m_p2v) m_g2 = m_p2[17:12];
    if (m_p1v) m_g1 = m_p1[11:6];
    if (word_vld_i && de_tag_i) m_g0 = word_i[5:0];
    if (word_vld_i && !de_tag_i) m_ctl = word_i[8:0];
    if (word_vld_i) m_de = de_tag_i;
    m_p2 = m_p1; m_p2v = m_p1v;
    m_p1 = word_i[17:0]; m_p1v = word_vld_i && de_tag_i;
    e.vid  = blank_i ? 18'h0 : {m_g2, m_g1, m_g0};
    e.ctl  = blank_i ? 9'h0 : m_ctl;
    e.de   = blank_i ? 1'b0 : m_de;
    e.pclk = ~rise_sel_i;
    e.drv  = oe_i;
    e.lock = lock_i;
    e.req  = cur_req;
    sb_q.push_back(e);
    -> chk_ev;
    @(negedge clk_i);
  endtask

  task automatic send(bit vld, bit tag, logic [26:0] w);
    word_vld_i = vld; de_tag_i = tag; word_i = w;
    tick();
    word_vld_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      word_i = {$urandom} & 27'h7ff_ffff;
      de_tag_i = i[0];
      tick();
    end
  endtask

  // monitor: sampled 5 ns after the rising edge, with the clock still high
  initial begin
    forever begin
      @(chk_ev);
      #5;
      begin
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        cmp(e.req, "video", 32'(video_o), 32'(e.vid));
        cmp(e.req, "ctl",   32'(ctl_o),   32'(e.ctl));
        cmp(e.req, "de",    32'(de_o),    32'(e.de));
        cmp(e.req, "pclk",  32'(pclk_o),  32'(e.pclk));
        cmp(e.req, "drive", 32'(pad_drive_o), 32'(e.drv));
        cmp(e.req, "lock",  32'(lock_o),  32'(e.lock));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_g0 = '0; m_g1 = '0; m_g2 = '0; m_ctl = '0; m_de = 1'b0;
    m_p1 = '0; m_p2 = '0; m_p1v = 1'b0; m_p2v = 1'b0;
    word_i = 27'h7ff_ffff; de_tag_i = 1'b1; word_vld_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R8: outputs stay cleared under reset even with a strobe present
    n_tests++;
    cmp("R8", "video", 32'(video_o), 0);
    cmp("R8", "ctl", 32'(ctl_o), 0);
    cmp("R8", "de", 32'(de_o), 0);
    word_vld_i = 1'b0;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    cur_req = "R8"; idle(2);
    cur_req = "R1"; send(1, 1, 27'h5a_cf35);
    cur_req = "R4"; idle(3);
    cur_req = "R2"; send(1, 0, 27'h7ff_ff5a);
    cur_req = "R3"; idle(4);
    cur_req = "R3"; send(1, 1, 27'h012_3456); idle(3);
    cur_req = "R4"; send(1, 1, 27'h3f_fc0f); send(1, 1, 27'h0_03f0); send(1, 0, 27'h1a5);
    idle(4);
    cur_req = "R7"; blank_i = 1'b1; idle(1);
    send(1, 1, 27'h2_aaaa); send(1, 0, 27'h0cc); idle(3);
    blank_i = 1'b0; idle(2);
    cur_req = "R5"; oe_i = 1'b0; send(1, 1, 27'h1_5555); idle(3);
    oe_i = 1'b1; idle(1);
    cur_req = "R9"; lock_i = 1'b1; idle(2); lock_i = 1'b0; idle(1);
    cur_req = "R6"; rise_sel_i = 1'b0; idle(2); rise_sel_i = 1'b1; idle(2);

    #6;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule